// File: doc/BRIEF.md
# Delay-Line TDC Timestamp Encoder

This block converts the captured state of a tapped delay line into an arrival timestamp. A free-running coarse counter advances once per sampling-clock period. On each hit strobe the block takes a snapshot of the delay-line taps, which are shared by all channels, and of the interpolation taps that belong to the channel that fired. It locates the clock edge in both snapshots and combines the two positions into a 7-bit fine field. The fine field is then joined with the coarse count to form a time word referenced to the last reset.

With 32 delay taps and 4 interpolation taps per delay interval, one coarse period is split into 128 fine bins. At a 3.125 ns period each fine bin is about 24.41 ps. A snapshot taken while the edge is crossing from the last tap back to the first would belong to the previous coarse period. The coarse value for each hit is therefore chosen from the decoded tap position, so the counter field is never one count ahead. The result appears two clock cycles after the strobe as a one-cycle valid pulse that carries the channel number.

Top module: `tdc_stamp_encoder`

## Requirements
- R1: The coarse counter is 0 in the first cycle after a synchronous reset, increments by one every clock, and wraps modulo 4096.
- R2: The delay-tap position is the lowest index i in 0..30 with tap[i]=1 and tap[i+1]=0. When no such pair exists (edge between tap 31 and tap 0, all ones, all zeros), the position is 31.
- R3: When the delay snapshot contains more than one 1-to-0 transition (a bubble), the lowest-index transition is used.
- R4: The interpolation position follows the same rule over taps 0..3, giving 0..2 for a transition and 3 otherwise. Only lane hit_ch, bits [4*ch+3 : 4*ch] of rc_taps, is used, and the other lanes have no effect on the result.
- R5: stamp_fine = delay position * 4 + interpolation position. The delay position sits in bits 6:2 and the interpolation position in bits 1:0.
- R6: When the delay position is below 24, stamp_coarse equals the counter value C present in the cycle of the strobe.
- R7: When the delay position is 24 or above, stamp_coarse equals C-1 modulo 4096, so C=0 gives 4095.
- R8: stamp_valid is high for exactly one cycle, two clock edges after the edge that samples hit_valid. stamp_ch repeats hit_ch. Strobes on back-to-back cycles give back-to-back results.
- R9: Reset drops any hit still in the pipeline, and no stamp_valid results from it.
- R10: stamp_valid stays low when no hit strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one coarse period |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | Hit strobe, snapshots valid this cycle |
| hit_ch | input | 3 | Channel that produced the hit |
| dll_taps | input | 32 | Shared delay-line tap snapshot |
| rc_taps | input | 32 | Interpolation taps, 4 per channel, lane n at bits [4n+3:4n] |
| stamp_valid | output | 1 | One-cycle result strobe |
| stamp_ch | output | 3 | Channel of the result |
| stamp_coarse | output | 12 | Coarse period count, wrap-corrected |
| stamp_fine | output | 7 | Fine bin within the period |

## Verification
Four properties are checked on every cycle:
- the counter steps by one each cycle;
- each decoded position really sits on a 1-to-0 pair;
- a result strobe always follows a hit strobe two cycles earlier and keeps its channel;
- the coarse field is the live count minus two or minus three, depending on whether the fine field is below or above the late-tap threshold.

Only the bench scenarios can show the following:
- that the lowest transition wins over a bubble;
- that the no-transition patterns map to the last tap;
- that the wrap case at a count of zero gives 4095;
- that other channels' interpolation lanes are ignored;
- that a hit caught by reset never emerges.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int DEF_NUM_CH   = 8;
  localparam int DEF_DLL_TAPS = 32;
  localparam int DEF_RC_TAPS  = 4;
  localparam int DEF_COARSE_W = 12;
endpackage

// File: rtl/tdc_therm_decoder.sv
module tdc_therm_decoder #(
  parameter int N = 32,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] taps,
  output logic [W-1:0] pos
);
  // lowest 1->0 pair wins; no pair maps to the last tap
  always_comb begin
    pos = W'(N - 1);
    for (int i = N - 2; i >= 0; i--) begin
      if (taps[i] && !taps[i+1]) pos = W'(i);
    end
  end

  // R2 / R4: a position below the last tap must lie on a real transition
  always_comb begin
    if (int'(pos) < N - 1) begin
      a_r2_edge_on_transition: assert (taps[int'(pos)] && !taps[int'(pos) + 1]);
    end
  end
endmodule

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cnt == WIDTH'($past(cnt) + 1'b1));
endmodule

// File: rtl/tdc_stamp_encoder.sv
module tdc_stamp_encoder
  import tdc_pkg::*;
#(
  parameter int NUM_CH   = DEF_NUM_CH,
  parameter int DLL_TAPS = DEF_DLL_TAPS,
  parameter int RC_TAPS  = DEF_RC_TAPS,
  parameter int COARSE_W = DEF_COARSE_W,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int DLL_W   = $clog2(DLL_TAPS),
  localparam int RC_W    = $clog2(RC_TAPS),
  localparam int FINE_W  = DLL_W + RC_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hit_valid,
  input  logic [CH_W-1:0]           hit_ch,
  input  logic [DLL_TAPS-1:0]       dll_taps,
  input  logic [NUM_CH*RC_TAPS-1:0] rc_taps,
  output logic                      stamp_valid,
  output logic [CH_W-1:0]           stamp_ch,
  output logic [COARSE_W-1:0]       stamp_coarse,
  output logic [FINE_W-1:0]         stamp_fine
);
  localparam int LATE_TAP = (DLL_TAPS * 3) / 4;
  localparam int LATE_FINE = LATE_TAP * RC_TAPS;

  logic [COARSE_W-1:0] cnt;
  logic [DLL_W-1:0]    dll_pos;
  logic [RC_W-1:0]     rc_pos;
  logic [RC_TAPS-1:0]  rc_lane;

  tdc_coarse_counter #(.WIDTH(COARSE_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt)
  );

  tdc_therm_decoder #(.N(DLL_TAPS)) u_dll_dec (
    .taps(dll_taps), .pos(dll_pos)
  );

  assign rc_lane = rc_taps[int'(hit_ch) * RC_TAPS +: RC_TAPS];

  tdc_therm_decoder #(.N(RC_TAPS)) u_rc_dec (
    .taps(rc_lane), .pos(rc_pos)
  );

  // stage 1: capture decoded positions and the live count
  logic                s1_valid;
  logic [CH_W-1:0]     s1_ch;
  logic [DLL_W-1:0]    s1_dll;
  logic [RC_W-1:0]     s1_rc;
  logic [COARSE_W-1:0] s1_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= hit_valid;
    end
    if (hit_valid) begin
      s1_ch  <= hit_ch;
      s1_dll <= dll_pos;
      s1_rc  <= rc_pos;
      s1_cnt <= cnt;
    end
  end

  // stage 2: wrap-corrected coarse field and registered outputs
  logic s1_late;
  assign s1_late = (int'(s1_dll) >= LATE_TAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_valid <= 1'b0;
    end else begin
      stamp_valid <= s1_valid;
    end
    if (s1_valid) begin
      stamp_ch     <= s1_ch;
      stamp_fine   <= {s1_dll, s1_rc};
      stamp_coarse <= s1_late ? COARSE_W'(s1_cnt - 1'b1) : s1_cnt;
    end
  end

  a_r8_valid_follows_hit: assert property (@(posedge clk) disable iff (rst)
    stamp_valid |-> $past(hit_valid, 2));

  a_r8_channel_kept: assert property (@(posedge clk) disable iff (rst)
    stamp_valid |-> stamp_ch == $past(hit_ch, 2));

  a_r6_coarse_current: assert property (@(posedge clk) disable iff (rst)
    (stamp_valid && int'(stamp_fine) < LATE_FINE) |-> stamp_coarse == COARSE_W'(cnt - 2'd2));

  a_r7_coarse_previous: assert property (@(posedge clk) disable iff (rst)
    (stamp_valid && int'(stamp_fine) >= LATE_FINE) |-> stamp_coarse == COARSE_W'(cnt - 2'd3));
endmodule

// File: tb/tb_tdc_stamp_encoder.sv
module tb_tdc_stamp_encoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hit_valid = 1'b0;
  logic [2:0]  hit_ch = '0;
  logic [31:0] dll_taps = '0;
  logic [31:0] rc_taps = '0;
  logic        stamp_valid;
  logic [2:0]  stamp_ch;
  logic [11:0] stamp_coarse;
  logic [6:0]  stamp_fine;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tdc_stamp_encoder dut (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_ch(hit_ch),
    .dll_taps(dll_taps), .rc_taps(rc_taps), .stamp_valid(stamp_valid),
    .stamp_ch(stamp_ch), .stamp_coarse(stamp_coarse), .stamp_fine(stamp_fine)
  );

  // reference count per R1, kept by the bench
  logic [11:0] mcnt = '0;
  always @(posedge clk) mcnt <= rst ? 12'd0 : mcnt + 12'd1;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [2:0]  ch;
    logic [31:0] dll;
    logic [3:0]  rc;
    logic [6:0]  fine;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_00FF, 4'b0011, 7'd29},   // R2 R4 plain
    '{3'd3, 32'h0000_0001, 4'b0001, 7'd0},    // R2 lowest position
    '{3'd5, 32'h7FFF_FFFF, 4'b0111, 7'd122},  // R7 late tap 30
    '{3'd7, 32'h8000_0000, 4'b1111, 7'd127},  // R2 wrap 31->0
    '{3'd2, 32'h0000_0F0F, 4'b1101, 7'd12},   // R3 bubble in both
    '{3'd1, 32'h00FF_FFFF, 4'b0111, 7'd94},   // R6 tap 23 boundary
    '{3'd4, 32'h01FF_FFFF, 4'b0000, 7'd99},   // R7 tap 24 boundary
    '{3'd6, 32'h0000_0000, 4'b0001, 7'd124},  // R2 all zeros
    '{3'd0, 32'hFFFF_FFFF, 4'b0011, 7'd125},  // R2 all ones
    '{3'd2, 32'hFFFF_0000, 4'b0001, 7'd124}   // R3 only wrap pair
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fill_lanes(input logic [2:0] ch, input logic [3:0] rc);
    logic [31:0] r;
    for (int k = 0; k < 8; k++) r[k*4 +: 4] = (k == int'(ch)) ? rc : ~rc;
    return r;
  endfunction

  function automatic logic [11:0] exp_coarse(input logic [11:0] c, input logic [6:0] fine);
    return (fine >= 7'd96) ? c - 12'd1 : c;
  endfunction

  // called at a negedge; returns at a negedge
  task automatic apply_hit(input vec_t v, input string tag);
    logic [11:0] ec;
    hit_valid = 1'b1; hit_ch = v.ch; dll_taps = v.dll;
    rc_taps = fill_lanes(v.ch, v.rc);
    ec = exp_coarse(mcnt, v.fine);
    @(negedge clk);
    hit_valid = 1'b0; dll_taps = ~v.dll; rc_taps = ~rc_taps;
    @(negedge clk);
    chk({tag, " R8 valid"}, 32'(stamp_valid), 32'd1);
    chk({tag, " R8 channel"}, 32'(stamp_ch), 32'(v.ch));
    chk({tag, " R5 fine"}, 32'(stamp_fine), 32'(v.fine));
    chk({tag, " R6/R7 coarse"}, 32'(stamp_coarse), 32'(ec));
    @(negedge clk);
    chk({tag, " R8 single pulse"}, 32'(stamp_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset count output idle", 32'(stamp_valid), 32'd0);
    // R7 wrap at count zero: hit in the first cycle out of reset
    rst = 1'b0;
    apply_hit('{3'd7, 32'h8000_0000, 4'b1111, 7'd127}, "R7 C=0");
    chk("R7 coarse wraps to 4095 (seen above)", 32'(exp_coarse(12'd0, 7'd127)), 32'd4095);

    // R10 idle: nothing emerges without a hit
    repeat (5) begin
      @(negedge clk);
      chk("R10 idle no valid", 32'(stamp_valid), 32'd0);
    end

    for (int i = 0; i < NV; i++) begin
      apply_hit(VECS[i], $sformatf("vec%0d", i));
      repeat (i) @(negedge clk);
    end

    // R1: counter wraps modulo 4096; hit after a long wait
    repeat (4100) @(negedge clk);
    apply_hit('{3'd1, 32'h0000_0003, 4'b0011, 7'd5}, "R1 after wrap");

    // R8 back-to-back hits
    begin
      logic [11:0] c_a;
      logic [11:0] c_b;
      hit_valid = 1'b1; hit_ch = 3'd2; dll_taps = 32'h0000_003F;
      rc_taps = fill_lanes(3'd2, 4'b0001); c_a = mcnt;
      @(negedge clk);
      hit_ch = 3'd6; dll_taps = 32'h0FFF_FFFF;
      rc_taps = fill_lanes(3'd6, 4'b0011); c_b = mcnt - 12'd1;
      @(negedge clk);
      hit_valid = 1'b0;
      chk("R8 b2b first valid", 32'(stamp_valid), 32'd1);
      chk("R8 b2b first channel", 32'(stamp_ch), 32'd2);
      chk("R5 b2b first fine", 32'(stamp_fine), 32'd20);
      chk("R6 b2b first coarse", 32'(stamp_coarse), 32'(c_a));
      @(negedge clk);
      chk("R8 b2b second valid", 32'(stamp_valid), 32'd1);
      chk("R8 b2b second channel", 32'(stamp_ch), 32'd6);
      chk("R5 b2b second fine", 32'(stamp_fine), 32'd109);
      chk("R7 b2b second coarse", 32'(stamp_coarse), 32'(c_b));
      @(negedge clk);
      chk("R8 b2b ends", 32'(stamp_valid), 32'd0);
    end

    // R9 reset drops a pending hit and clears the count
    begin
      int seen = 0;
      hit_valid = 1'b1; hit_ch = 3'd4; dll_taps = 32'h0000_000F;
      rc_taps = fill_lanes(3'd4, 4'b0001);
      @(negedge clk);
      hit_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (stamp_valid) seen++;
        @(negedge clk);
      end
      chk("R9 pending hit dropped", 32'(seen), 32'd0);
    end

    // R1/R9 count restarts from zero after reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    apply_hit('{3'd0, 32'h0000_0001, 4'b0000, 7'd3}, "R1 count restart");
    chk("R1 restart count model", 32'(mcnt), 32'd6);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule